// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block decides what a display controller pulls from memory once a load is started: a colour lookup table alone, a frame alone, or a lookup table followed by a frame. Data arrives as 32-bit words on a request/valid stream. The block raises `fetch_req` while it can take a word, and a word counts only in a cycle where both `fetch_req` and `word_valid` are high. Lookup-table words carry two 16-bit entries each. The pixel depth of the following frame is not set by a control bit. It is a code in the top nibble of the very first entry, and that code also fixes how many table words are fetched.

Frame words are cut into pixels, least significant pixel first. At 1, 2, 4 and 8 bits per pixel each pixel is an index into an internal 256-entry table of 12-bit colours. At 16 bits per pixel each halfword carries its colour directly. Pixels leave as a stream of `pix_valid` and `pix_color`. Two sticky flags report progress: one says the table has been fully received, the other says the frame has been fully emitted.

Top module: `pal_frame_loader`

## Requirements
- R1: `load_mode` is sampled when `start` is high while idle. Value 0 fetches the table and then the frame. Value 1 fetches only the table, after which the block returns to idle without requesting any frame word. Value 2 fetches only the frame, using the depth and table left by the previous table load.
- R2: A `start` with `load_mode` equal to 3 has no effect: the block stays idle, requests nothing and both flags keep their values.
- R3: Bits [15:12] of the low halfword of the first table word give the depth code: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 16 bpp direct colour. Codes above 4 act as 4. `depth_code` shows the decoded code 0..4 and resets to 4.
- R4: A table load accepts exactly (table bytes / 4 + 1) words. The table size is 256 bytes at codes 0..2, 512 bytes at code 3 and 32 bytes at code 4, which gives 65, 129 or 9 words.
- R5: Table word n carries entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. The colour of each entry is its bits [11:0]: red [11:8], green [7:4], blue [3:0]. Entries numbered 256 and above are discarded and leave entries 0..255 untouched.
- R6: `pal_loaded` goes high in the cycle after the last table word is accepted. `frame_done` goes high together with the last pixel of the frame. Both are cleared by the next accepted `start`.
- R7: Each frame word yields 32/bpp pixels, taken from the least significant bits upward. In indexed depths `pix_color` is the table colour at that index. At 16 bpp it is bits [11:0] of each halfword, low halfword first.
- R8: A frame phase accepts exactly `frame_len` words. With `frame_len` 0 it ends with `frame_done` and emits no pixel.
- R9: Words offered while `fetch_req` is low, including while idle, are ignored: they change neither the table nor the depth.
- R10: After reset the block is idle, with `fetch_req`, `busy`, both flags and `pix_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| load_mode | input | 2 | Fetch sequence selector (R1, R2) |
| frame_len | input | LEN_W | Frame length in 32-bit words |
| word_valid | input | 1 | Word on `word_data` is offered |
| word_data | input | 32 | Incoming data word |
| fetch_req | output | 1 | Block can accept a word this cycle |
| busy | output | 1 | A load is in progress |
| pal_loaded | output | 1 | Table fully received |
| frame_done | output | 1 | Frame fully emitted |
| depth_code | output | 3 | Current decoded depth code |
| pix_valid | output | 1 | Pixel on `pix_color` is valid |
| pix_color | output | COLOR_W | Output pixel colour |

## Verification
The bench builds the block with its default parameters: 256 table entries, 12-bit colours, a 12-bit frame length and an 8-bit word counter. These values let a full 8 bpp table of 129 words reach the two surplus entries, so discarding them can be observed against entries 0, 1, 254 and 255 through the pixel output. A table of vectors covers every depth code including a code above 4, all three fetch sequences, frame-only loads that reuse an earlier table, and stalled input streams. Directed cases cover words offered while idle, the reserved mode and a zero-length frame.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PAL   = 2'd1,
    PH_FRAME = 2'd2
  } phase_t;

  localparam logic [1:0] LM_BOTH  = 2'd0;
  localparam logic [1:0] LM_PAL   = 2'd1;
  localparam logic [1:0] LM_FRAME = 2'd2;
  localparam logic [1:0] LM_RSVD  = 2'd3;

  localparam int unsigned TBL_BYTES_SMALL = 256;
  localparam int unsigned TBL_BYTES_BYTE  = 512;
  localparam int unsigned TBL_BYTES_WIDE  = 32;
  localparam logic [2:0]  DEPTH_DIRECT    = 3'd4;

  function automatic logic [2:0] depth_of(input logic [3:0] code);
    return (code > 4'd4) ? DEPTH_DIRECT : code[2:0];
  endfunction

  function automatic int unsigned tbl_words(input logic [2:0] d);
    int unsigned bytes;
    if (d < 3'd3)       bytes = TBL_BYTES_SMALL;
    else if (d == 3'd3) bytes = TBL_BYTES_BYTE;
    else                bytes = TBL_BYTES_WIDE;
    return bytes / 4 + 1;
  endfunction

  function automatic logic [4:0] bpp_of(input logic [2:0] d);
    return (d <= 3'd3) ? (5'd1 << d) : 5'd16;
  endfunction

  function automatic logic [5:0] pix_per_word(input logic [2:0] d);
    return (d <= 3'd3) ? (6'd32 >> d) : 6'd2;
  endfunction

endpackage

// File: rtl/pfl_rst_sync.sv
module pfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pfl_ctrl.sv
module pfl_ctrl
  import pfl_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       load_mode,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             word_valid,
  input  logic [3:0]       code_nib,
  input  logic             ser_empty,
  input  logic             ser_last,
  output logic             fetch_req,
  output logic             tbl_take,
  output logic             frm_take,
  output logic [CNT_W-1:0] tbl_idx,
  output logic [2:0]       depth,
  output logic             busy,
  output logic             pal_loaded,
  output logic             frame_done
);

  phase_t             phase_q, phase_d;
  logic [1:0]         mode_q, mode_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [CNT_W-1:0]   wcnt_q, wcnt_d;
  logic [2:0]         depth_q, depth_d;
  logic               pl_q, pl_d;
  logic               fd_q, fd_d;
  logic [2:0]         depth_now;
  logic [CNT_W-1:0]   tbl_total;
  logic               take;

  always_comb begin
    fetch_req = (phase_q == PH_PAL) ||
                ((phase_q == PH_FRAME) && ser_empty && (left_q != '0));
    take      = fetch_req && word_valid;
    tbl_take  = take && (phase_q == PH_PAL);
    frm_take  = take && (phase_q == PH_FRAME);
    depth_now = (wcnt_q == '0) ? depth_of(code_nib) : depth_q;
    tbl_total = CNT_W'(tbl_words(depth_now));
  end

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    left_d  = left_q;
    wcnt_d  = wcnt_q;
    depth_d = depth_q;
    pl_d    = pl_q;
    fd_d    = fd_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start && (load_mode != LM_RSVD)) begin
          mode_d  = load_mode;
          left_d  = frame_len;
          wcnt_d  = '0;
          pl_d    = 1'b0;
          fd_d    = 1'b0;
          phase_d = (load_mode == LM_FRAME) ? PH_FRAME : PH_PAL;
        end
      end
      PH_PAL: begin
        if (tbl_take) begin
          if (wcnt_q == '0) depth_d = depth_now;
          if (wcnt_q == tbl_total - 1'b1) begin
            wcnt_d  = '0;
            pl_d    = 1'b1;
            phase_d = (mode_q == LM_PAL) ? PH_IDLE : PH_FRAME;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      PH_FRAME: begin
        if (frm_take) left_d = left_q - 1'b1;
        if ((left_q == '0) && (ser_empty || ser_last)) begin
          fd_d    = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= LM_BOTH;
      left_q  <= '0;
      wcnt_q  <= '0;
      depth_q <= DEPTH_DIRECT;
      pl_q    <= 1'b0;
      fd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      left_q  <= left_d;
      wcnt_q  <= wcnt_d;
      depth_q <= depth_d;
      pl_q    <= pl_d;
      fd_q    <= fd_d;
    end
  end

  assign tbl_idx    = wcnt_q;
  assign depth      = depth_q;
  assign busy       = (phase_q != PH_IDLE);
  assign pal_loaded = pl_q;
  assign frame_done = fd_q;

  // R1
  pal_only_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FRAME) |-> (mode_q != LM_PAL));

  // R2
  rsvd_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_IDLE) && start && (load_mode == LM_RSVD)) |=> (phase_q == PH_IDLE));

  // R6
  tbl_flag_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pl_q) |-> $past(tbl_take));

  // R6
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fd_q) |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/pfl_unpack.sv
module pfl_unpack
  import pfl_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [31:0]        word,
  input  logic [2:0]         depth,
  output logic               emit,
  output logic               last,
  output logic               empty,
  output logic [IDX_W-1:0]   idx,
  output logic [COLOR_W-1:0] direct
);

  logic [31:0] sh_q, sh_d;
  logic [5:0]  cnt_q, cnt_d;
  logic [7:0]  raw_idx;

  always_comb begin
    empty = (cnt_q == '0);
    emit  = !empty;
    last  = (cnt_q == 6'd1);
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = word;
      cnt_d = pix_per_word(depth);
    end else if (emit) begin
      sh_d  = sh_q >> bpp_of(depth);
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    unique case (depth)
      3'd0:    raw_idx = {7'd0, sh_q[0]};
      3'd1:    raw_idx = {6'd0, sh_q[1:0]};
      3'd2:    raw_idx = {4'd0, sh_q[3:0]};
      default: raw_idx = sh_q[7:0];
    endcase
    idx    = IDX_W'(raw_idx);
    direct = sh_q[COLOR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load || emit) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R7
  load_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/pfl_lut_ram.sv
module pfl_lut_ram #(
  parameter int ENTRIES = 256,
  parameter int COLOR_W = 12,
  parameter int ADDR_W  = 9,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  wa0,
  input  logic [COLOR_W-1:0] wd0,
  input  logic [ADDR_W-1:0]  wa1,
  input  logic [COLOR_W-1:0] wd1,
  input  logic [IDX_W-1:0]   ra,
  output logic [COLOR_W-1:0] rd
);

  logic [COLOR_W-1:0] rd_arr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic               hit0, hit1;
    logic [COLOR_W-1:0] ent_q;
    assign hit0 = we && (wa0 == ADDR_W'(i));
    assign hit1 = we && (wa1 == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (hit0)      ent_q <= wd0;
      else if (hit1) ent_q <= wd1;
    end
    assign rd_arr[i] = ent_q;
  end

  assign rd = rd_arr[ra];

  // R5
  distinct_write_chk: assert property (@(posedge clk)
    we |-> (wa0 != wa1));

endmodule

// File: rtl/pal_frame_loader.sv
module pal_frame_loader
  import pfl_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COLOR_W = 12,
  parameter int LEN_W   = 12,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         load_mode,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               word_valid,
  input  logic [31:0]        word_data,
  output logic               fetch_req,
  output logic               busy,
  output logic               pal_loaded,
  output logic               frame_done,
  output logic [2:0]         depth_code,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int ADDR_W = CNT_W + 1;

  logic               rst_sync_n;
  logic               tbl_take, frm_take;
  logic [CNT_W-1:0]   tbl_idx;
  logic [2:0]         depth;
  logic               ser_emit, ser_last, ser_empty;
  logic [IDX_W-1:0]   ser_idx;
  logic [COLOR_W-1:0] ser_direct, lut_rd, pix_d;
  logic               pv_q;
  logic [COLOR_W-1:0] pc_q;

  pfl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pfl_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .load_mode  (load_mode),
    .frame_len  (frame_len),
    .word_valid (word_valid),
    .code_nib   (word_data[15:12]),
    .ser_empty  (ser_empty),
    .ser_last   (ser_last),
    .fetch_req  (fetch_req),
    .tbl_take   (tbl_take),
    .frm_take   (frm_take),
    .tbl_idx    (tbl_idx),
    .depth      (depth),
    .busy       (busy),
    .pal_loaded (pal_loaded),
    .frame_done (frame_done)
  );

  pfl_unpack #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_unpack (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (frm_take),
    .word   (word_data),
    .depth  (depth),
    .emit   (ser_emit),
    .last   (ser_last),
    .empty  (ser_empty),
    .idx    (ser_idx),
    .direct (ser_direct)
  );

  pfl_lut_ram #(.ENTRIES(ENTRIES), .COLOR_W(COLOR_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lut (
    .clk (clk),
    .we  (tbl_take),
    .wa0 ({tbl_idx, 1'b0}),
    .wd0 (word_data[COLOR_W-1:0]),
    .wa1 ({tbl_idx, 1'b1}),
    .wd1 (word_data[16 +: COLOR_W]),
    .ra  (ser_idx),
    .rd  (lut_rd)
  );

  assign pix_d = (depth == DEPTH_DIRECT) ? ser_direct : lut_rd;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pv_q <= 1'b0;
      pc_q <= '0;
    end else begin
      pv_q <= ser_emit;
      if (ser_emit) pc_q <= pix_d;
    end
  end

  assign pix_valid  = pv_q;
  assign pix_color  = pc_q;
  assign depth_code = depth;

  // R7
  pix_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pv_q |-> $past(busy));

  // R1
  busy_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (pal_loaded || frame_done));

endmodule

// File: tb/pal_frame_loader_tb_top.sv
module pal_frame_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int COLOR_W    = 12;
  localparam int WD_LIMIT   = 100000;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] code;
    logic [3:0] flen;
    logic [7:0] seed;
    logic       gap;
    logic       pat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd3, 4'd3, 8'h11, 1'b0, 1'b0},
    '{2'd2, 4'd0, 4'd2, 8'h22, 1'b1, 1'b0},
    '{2'd0, 4'd0, 4'd2, 8'h33, 1'b1, 1'b0},
    '{2'd0, 4'd1, 4'd2, 8'h44, 1'b0, 1'b0},
    '{2'd0, 4'd2, 4'd3, 8'h55, 1'b1, 1'b0},
    '{2'd0, 4'd4, 4'd3, 8'h66, 1'b0, 1'b0},
    '{2'd0, 4'd9, 4'd2, 8'h77, 1'b1, 1'b0},
    '{2'd1, 4'd3, 4'd0, 8'h88, 1'b0, 1'b0},
    '{2'd2, 4'd0, 4'd4, 8'h99, 1'b0, 1'b1},
    '{2'd0, 4'd3, 4'd0, 8'hAA, 1'b1, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [1:0]         load_mode;
  logic [LEN_W-1:0]   frame_len;
  logic               word_valid;
  logic [31:0]        word_data;
  logic               fetch_req, busy, pal_loaded, frame_done, pix_valid;
  logic [2:0]         depth_code;
  logic [COLOR_W-1:0] pix_color;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_frame_loader dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .load_mode  (load_mode),
    .frame_len  (frame_len),
    .word_valid (word_valid),
    .word_data  (word_data),
    .fetch_req  (fetch_req),
    .busy       (busy),
    .pal_loaded (pal_loaded),
    .frame_done (frame_done),
    .depth_code (depth_code),
    .pix_valid  (pix_valid),
    .pix_color  (pix_color)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [11:0] pal_m [256];
  int          depth_m = 4;
  logic [31:0] words [320];
  int          nwords = 0;
  int          widx   = 0;
  bit          gap_en = 0;
  bit          junk_en = 0;
  logic [11:0] exp_pix [160];
  int          nexp = 0;
  int          nseen = 0;

  task automatic check(input bit ok, input string req, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog got %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // word source: offers words only while the block requests (except junk)
  always @(negedge clk) begin
    if (word_valid && !junk_en) widx++;
    if (junk_en) begin
      word_valid = 1'b1;
      word_data  = 32'hFFFF_F5A5;
    end else begin
      word_valid = fetch_req && (widx < nwords) && !(gap_en && (cyc % 3 == 0));
      word_data  = words[(widx < 320) ? widx : 0];
    end
  end

  // pixel monitor (R7)
  always @(negedge clk) begin
    if (pix_valid) begin
      if (nseen < nexp)
        check(pix_color == exp_pix[nseen], "R7 pixel", int'(pix_color), int'(exp_pix[nseen]));
      nseen++;
    end
  end

  function automatic logic [11:0] colr(input int e, input logic [7:0] s);
    return 12'(e * 37 + int'(s) * 5 + 1);
  endfunction

  function automatic int tblw(input int d);
    return (d < 3) ? 65 : ((d == 3) ? 129 : 9);
  endfunction

  task automatic run_vec(input vec_t v, input string tag);
    int dm;
    int bpp;
    logic [15:0] lo, hi;
    logic [31:0] fw, sh;
    nwords = 0;
    nexp   = 0;
    if (v.mode != 2'd2) begin
      dm = (v.code > 4) ? 4 : int'(v.code);
      for (int w = 0; w < tblw(dm); w++) begin
        lo = (w == 0) ? {v.code, colr(0, v.seed)} : {4'(2*w), colr(2*w, v.seed)};
        hi = {4'(2*w+1), colr(2*w+1, v.seed)};
        words[nwords] = {hi, lo};
        nwords++;
        if (2*w < 256)   pal_m[2*w]   = colr(2*w, v.seed);
        if (2*w+1 < 256) pal_m[2*w+1] = colr(2*w+1, v.seed);
      end
      depth_m = dm;
    end
    if (v.mode != 2'd1) begin
      bpp = (depth_m <= 3) ? (1 << depth_m) : 16;
      for (int k = 0; k < int'(v.flen); k++) begin
        fw = v.pat ? ((k % 2 == 0) ? 32'hFF01_00FE : 32'h0001_FF00)
                   : ({4{v.seed}} ^ (32'(k) * 32'h9E37_79B1));
        words[nwords] = fw;
        nwords++;
        for (int p = 0; p < 32 / bpp; p++) begin
          sh = fw >> (p * bpp);
          if (depth_m == 4) exp_pix[nexp] = sh[11:0];
          else              exp_pix[nexp] = pal_m[sh & ((32'd1 << bpp) - 1)];
          nexp++;
        end
      end
    end
    widx      = 0;
    nseen     = 0;
    gap_en    = v.gap;
    load_mode = v.mode;
    frame_len = LEN_W'(v.flen);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    // R4 / R8: exact number of words taken
    check(widx == nwords, {tag, " R4 R8 words taken"}, widx, nwords);
    check(nseen == nexp, {tag, " R8 pixel count"}, nseen, nexp);
    // R6 flags
    check(pal_loaded == (v.mode != 2'd2), {tag, " R6 pal_loaded"}, int'(pal_loaded), int'(v.mode != 2'd2));
    check(frame_done == (v.mode != 2'd1), {tag, " R6 frame_done"}, int'(frame_done), int'(v.mode != 2'd1));
    // R3 depth decode
    check(int'(depth_code) == depth_m, {tag, " R3 depth_code"}, int'(depth_code), depth_m);
    // R1 sequence end
    check(!busy && !fetch_req, {tag, " R1 stopped"}, int'({busy, fetch_req}), 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    load_mode  = 2'd0;
    frame_len  = '0;
    word_valid = 1'b0;
    word_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check({fetch_req, busy, pal_loaded, frame_done, pix_valid} == 5'b0, "R10 reset outputs",
          int'({fetch_req, busy, pal_loaded, frame_done, pix_valid}), 0);
    check(depth_code == 3'd4, "R10 reset depth", int'(depth_code), 4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R9 words while idle are ignored
    junk_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!fetch_req && !busy, "R9 idle stays idle", int'({fetch_req, busy}), 0);
    end
    junk_en = 1'b0;
    @(negedge clk);
    run_vec('{2'd2, 4'd0, 4'd2, 8'hC3, 1'b0, 1'b1}, "r9_after_junk");

    // R2 reserved mode ignored
    begin
      logic pl0, fd0;
      pl0 = pal_loaded;
      fd0 = frame_done;
      load_mode = 2'd3;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check(!busy && !fetch_req, "R2 reserved mode idle", int'({busy, fetch_req}), 0);
      end
      check(pal_loaded == pl0 && frame_done == fd0, "R2 flags kept",
            int'({pal_loaded, frame_done}), int'({pl0, fd0}));
    end

    // R5 surplus entries must not disturb 0,1,254,255
    run_vec('{2'd0, 4'd3, 4'd2, 8'h5D, 1'b0, 1'b1}, "r5_discard");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule